// File: doc/BRIEF.md
# Cascaded Decimal (BCD) Adder

This block adds two unsigned decimal numbers, each held as packed binary-coded decimal digits, together with a one-bit carry-in. It is purely combinational. The result comes back as packed decimal digits plus a single carry bit. That carry bit acts as a half digit, so with the default four digits the result spans 00000 to 19999.

Each digit slice works in two steps. First it forms the five-bit binary total of its two operand digits and the carry from the slice below. A carry-detect function of that total then decides whether the total has left the decimal range. When it has, six is added to the low four bits, the overflow of that second addition is dropped, and a decimal carry is passed to the next more significant slice. The slices ripple from the units digit upward.

A separate screen raises a flag whenever an operand nibble holds a non-decimal code (ten to fifteen). The sum outputs carry no defined meaning while that flag is high. The digit count is a parameter.

Top module: `bcd_ripple_adder`

## Requirements
- R1: Operands and result are packed BCD with the units digit in bits [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12]. For valid operands, the decimal value of {cout, sum} equals a + b + cin.
- R2: In any slice whose binary total (two digits plus incoming carry) is 0 to 9, the output digit equals that total and the slice produces no decimal carry.
- R3: In any slice whose binary total is 10 to 19, the slice produces a decimal carry and its output digit is the total minus ten. This is the low four bits plus 0110, with the fifth bit dropped.
- R4: The decimal carry of each slice is the carry-in of the next more significant slice. A carry therefore ripples through a run of nines, for example 9999 + 0000 + 1 gives cout 1 and sum 0000.
- R5: cout is the decimal carry of the most significant slice and can only be 0 or 1. For valid operands every result digit lies in 0 to 9, and the largest result is 9999 + 9999 + 1 = 19999.
- R6: bad_digit is 1 exactly when at least one nibble of a or b holds a value above 1001 (10 to 15). Otherwise it is 0.
- R7: cin adds one unit to the result: all-zero operands give 0000 with cout 0 when cin is 0, and 0001 when cin is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand, packed BCD, units in [3:0] |
| b | input | 16 | Second operand, packed BCD, units in [3:0] |
| cin | input | 1 | Carry into the units digit |
| sum | output | 16 | Packed BCD result digits |
| cout | output | 1 | Half-digit carry out of the top digit |
| bad_digit | output | 1 | A nibble of a or b is not a decimal code |

## Verification
The block holds no state, so a wrong carry-detect term or a missing correction appears at the ports as soon as the inputs settle, in the same evaluation. A bad correction term shows up as a digit in the range 10 to 15, or as a digit that is six off. A broken ripple link shows up as a result that is off by a power of ten, and only when a lower digit's total reaches ten. For that reason the sweeps place every digit pair, with both carry-in values, in every digit position, and add runs of nines that force long carry chains.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

  localparam int DIGIT_W = 4;
  localparam int BIN_W   = DIGIT_W + 1;
  localparam logic [DIGIT_W-1:0] FIX_ADD = 4'b0110;

  // Decimal carry from the five-bit binary total of one slice.
  function automatic logic dec_carry(input logic [BIN_W-1:0] bin);
    return bin[4] | (bin[3] & bin[2]) | (bin[3] & bin[1]);
  endfunction

  // Correct the low four bits when a decimal carry is produced.
  function automatic logic [DIGIT_W-1:0] fix_digit(input logic [DIGIT_W-1:0] low,
                                                   input logic carry);
    logic [DIGIT_W-1:0] addend;
    addend = carry ? FIX_ADD : '0;
    return low + addend;
  endfunction

  // A nibble outside 0..9 has bit 3 set together with bit 2 or bit 1.
  function automatic logic nibble_bad(input logic [DIGIT_W-1:0] d);
    return d[3] & (d[2] | d[1]);
  endfunction

endpackage

// File: rtl/bcd_binsum.sv
module bcd_binsum
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] op_x,
  input  logic [DIGIT_W-1:0] op_y,
  input  logic               c_in,
  output logic [BIN_W-1:0]   total
);
  logic [BIN_W-1:0] ext_x;
  logic [BIN_W-1:0] ext_y;
  logic [BIN_W-1:0] ext_c;

  assign ext_x = {1'b0, op_x};
  assign ext_y = {1'b0, op_y};
  assign ext_c = {{(BIN_W-1){1'b0}}, c_in};
  assign total = ext_x + ext_y + ext_c;
endmodule

// File: rtl/bcd_correct.sv
module bcd_correct
  import bcd_add_pkg::*;
(
  input  logic [BIN_W-1:0]   total,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry
);
  logic need_fix;

  assign need_fix = dec_carry(total);
  assign carry    = need_fix;
  assign digit    = fix_digit(total[DIGIT_W-1:0], need_fix);
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_add_pkg::*;
(
  input  logic [DIGIT_W-1:0] dig_a,
  input  logic [DIGIT_W-1:0] dig_b,
  input  logic               carry_in,
  output logic [DIGIT_W-1:0] digit_out,
  output logic               carry_out,
  output logic [BIN_W-1:0]   bin_sum
);
  logic [BIN_W-1:0] raw_total;

  bcd_binsum u_bin (
    .op_x  (dig_a),
    .op_y  (dig_b),
    .c_in  (carry_in),
    .total (raw_total)
  );

  bcd_correct u_fix (
    .total (raw_total),
    .digit (digit_out),
    .carry (carry_out)
  );

  assign bin_sum = raw_total;
endmodule

// File: rtl/bcd_nibble_screen.sv
module bcd_nibble_screen
  import bcd_add_pkg::*;
#(
  parameter int NDIGITS = 4
) (
  input  logic [NDIGITS*DIGIT_W-1:0] op_a,
  input  logic [NDIGITS*DIGIT_W-1:0] op_b,
  output logic                       any_bad
);
  logic [NDIGITS-1:0] bad_a;
  logic [NDIGITS-1:0] bad_b;

  for (genvar g = 0; g < NDIGITS; g++) begin : g_scan
    assign bad_a[g] = nibble_bad(op_a[g*DIGIT_W +: DIGIT_W]);
    assign bad_b[g] = nibble_bad(op_b[g*DIGIT_W +: DIGIT_W]);
  end

  assign any_bad = (|bad_a) | (|bad_b);
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder
  import bcd_add_pkg::*;
#(
  parameter int NDIGITS = 4
) (
  input  logic [NDIGITS*4-1:0] a,
  input  logic [NDIGITS*4-1:0] b,
  input  logic                 cin,
  output logic [NDIGITS*4-1:0] sum,
  output logic                 cout,
  output logic                 bad_digit
);
  localparam int W  = NDIGITS * DIGIT_W;
  localparam int SW = NDIGITS * BIN_W;

  // Internal events brought out for the checker.
  logic [NDIGITS:0]   carry_chain;
  logic [NDIGITS-1:0] stage_carry;
  logic [SW-1:0]      stage_bin;
  logic [W-1:0]       digits;

  assign carry_chain[0] = cin;

  for (genvar g = 0; g < NDIGITS; g++) begin : g_digit
    bcd_digit_stage u_stage (
      .dig_a     (a[g*DIGIT_W +: DIGIT_W]),
      .dig_b     (b[g*DIGIT_W +: DIGIT_W]),
      .carry_in  (carry_chain[g]),
      .digit_out (digits[g*DIGIT_W +: DIGIT_W]),
      .carry_out (carry_chain[g+1]),
      .bin_sum   (stage_bin[g*BIN_W +: BIN_W])
    );
    assign stage_carry[g] = carry_chain[g+1];
  end

  bcd_nibble_screen #(.NDIGITS(NDIGITS)) u_screen (
    .op_a    (a),
    .op_b    (b),
    .any_bad (bad_digit)
  );

  assign sum  = digits;
  assign cout = carry_chain[NDIGITS];
endmodule

// File: rtl/bcd_ripple_adder_chk.sv
module bcd_ripple_adder_chk #(
  parameter int NDIGITS = 4
) (
  input logic [NDIGITS*4-1:0] a,
  input logic [NDIGITS*4-1:0] b,
  input logic                 cin,
  input logic [NDIGITS*4-1:0] sum,
  input logic                 cout,
  input logic                 bad_digit,
  input logic [NDIGITS-1:0]   stage_carry,
  input logic [NDIGITS*5-1:0] stage_bin
);
  always_comb begin
    for (int i = 0; i < NDIGITS; i++) begin
      logic [4:0] tot;
      logic [3:0] dg;
      logic       cprev;
      tot   = stage_bin[i*5 +: 5];
      dg    = sum[i*4 +: 4];
      cprev = (i == 0) ? cin : stage_carry[i-1];
      // R2: totals below ten pass unchanged with no carry
      if (tot < 5'd10) begin
        a_r2_pass_through: assert (stage_carry[i] == 1'b0 && {1'b0, dg} == tot);
      end
      // R3: totals ten to nineteen wrap by ten and carry
      if (tot >= 5'd10 && tot <= 5'd19) begin
        a_r3_wrap_by_ten: assert (stage_carry[i] == 1'b1 && {1'b0, dg} == tot - 5'd10);
      end
      // R4: each slice total includes the carry of the slice below
      a_r4_chain_link: assert (tot == {1'b0, a[i*4 +: 4]} + {1'b0, b[i*4 +: 4]} + {4'd0, cprev});
      // R5: every result digit stays decimal for valid operands
      if (!bad_digit) begin
        a_r5_digit_range: assert (dg <= 4'd9);
      end
    end
  end

  always_comb begin
    logic seen_bad;
    seen_bad = 1'b0;
    for (int i = 0; i < NDIGITS; i++) begin
      if (a[i*4 +: 4] > 4'd9 || b[i*4 +: 4] > 4'd9) seen_bad = 1'b1;
    end
    // R6: flag matches presence of a non-decimal nibble
    a_r6_bad_flag: assert (bad_digit == seen_bad);
    // R5: top carry is the last slice carry
    a_r5_top_carry: assert (cout == stage_carry[NDIGITS-1]);
  end
endmodule

bind bcd_ripple_adder bcd_ripple_adder_chk #(.NDIGITS(NDIGITS)) u_chk (
  .a           (a),
  .b           (b),
  .cin         (cin),
  .sum         (sum),
  .cout        (cout),
  .bad_digit   (bad_digit),
  .stage_carry (stage_carry),
  .stage_bin   (stage_bin)
);

// File: tb/tb_bcd_ripple_adder.sv
module tb_bcd_ripple_adder;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int W  = ND * 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic cin, cout, bad_digit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bcd_ripple_adder #(.NDIGITS(ND)) dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .bad_digit(bad_digit)
  );

  function automatic int bcd_value(input logic [W-1:0] v);
    int acc = 0;
    for (int k = ND - 1; k >= 0; k--) acc = acc * 10 + int'(v[k*4 +: 4]);
    return acc;
  endfunction

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int rest = v;
    for (int k = 0; k < ND; k++) begin
      r[k*4 +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h cin=%0b)", req, act, exp, a, b, cin);
    end
  endtask

  // Drive at the falling edge, sample one time unit later.
  task automatic add_case(input string req, input logic [W-1:0] va, input logic [W-1:0] vb,
                          input logic vc);
    int total;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    total = bcd_value(va) + bcd_value(vb) + int'(vc);
    check(req, {cout, sum}, {(total >= 10000) ? 1'b1 : 1'b0, to_bcd(total % 10000)});
    check("R6 clear", {{W{1'b0}}, bad_digit}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R7: zero operands, both carry-in values
    add_case("R7 zero", '0, '0, 1'b0);
    add_case("R7 unit", '0, '0, 1'b1);

    // R2 R3: every digit pair with both carries, in every digit position
    for (int pos = 0; pos < ND; pos++)
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++)
          for (int c = 0; c < 2; c++)
            add_case((x + y + c >= 10) ? "R3 digit" : "R2 digit",
                     W'(x) << (4*pos), W'(y) << (4*pos), 1'(c));

    // R4: long ripple through nines
    add_case("R4 ripple", 16'h9999, 16'h0000, 1'b1);
    add_case("R4 partial", 16'h0999, 16'h0000, 1'b1);
    add_case("R4 mid", 16'h5050, 16'h4949, 1'b1);
    // R5: largest result
    add_case("R5 max", 16'h9999, 16'h9999, 1'b1);
    add_case("R5 nocarry", 16'h9999, 16'h9999, 1'b0);

    // R1: random valid operands
    for (int n = 0; n < 2000; n++) begin
      add_case("R1 random", to_bcd(int'($urandom_range(9999))),
               to_bcd(int'($urandom_range(9999))), 1'($urandom_range(1)));
    end

    // R6: each non-decimal code in each nibble of each operand
    for (int pos = 0; pos < ND; pos++)
      for (int v = 10; v < 16; v++)
        for (int side = 0; side < 2; side++) begin
          @(negedge clk);
          a = (side == 0) ? (W'(v) << (4*pos)) : 16'h1234;
          b = (side == 1) ? (W'(v) << (4*pos)) : 16'h4321;
          cin = 1'b0;
          #1;
          check("R6 flag", {{W{1'b0}}, bad_digit}, {{W{1'b0}}, 1'b1});
        end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule